// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver

This block couples two data ports, A and B, through two independent one-way paths. Each path has its own output enable, latch enable and direction clock. With the latch enable high a path is transparent, and the far port shows the near port's data in the same cycle. With the latch enable low the path keeps its stored word. That word is replaced on a rising edge of the path's direction clock. One storage register per path serves as both the latch and the flip-flop.

All logic runs on a core clock `clk`. The direction clocks and latch enables are level inputs that are synchronous to `clk`. A rising edge of a direction clock is the first core cycle in which that clock reads high after reading low. The tri-state drivers outside the block are modelled by a data output and a separate drive-enable output for each port. A floating input is marked by a low "driven" qualifier. While an input floats, bus-hold logic presents the last word that was driven on it. The enable of the A-to-B path is active high. The enable of the B-to-A path is active low.

Top module: `bidir_xcvr`

## Requirements
- R1: While `rst_n` is low, both stored words, both bus-hold words and both edge detectors are cleared. Both data outputs read zero when their latch enables are low.
- R2: While `le_ab` is high, `b_out` equals the effective A word in the same cycle, with no clock delay.
- R3: While `le_ab` is low and no rising edge of `clk_ab` is seen, `b_out` keeps the word stored at the last core cycle in which `le_ab` was high or a rising edge was taken.
- R4: While `le_ab` is low, a rising edge of `clk_ab` stores the effective A word. `b_out` shows it from the next core cycle. A falling edge, or `clk_ab` held high, stores nothing.
- R5: `b_oe` is high exactly when `oe_ab` is high (active high). `b_out` is still computed while `b_oe` is low.
- R6: The B-to-A path behaves like R2 to R4, using `le_ba` and `clk_ba`, with B as the source and `a_out` as the result.
- R7: `a_oe` is high exactly when `oe_ba_n` is low (active low).
- R8: While a port's driven qualifier (`a_in_vld` or `b_in_vld`) is low, the effective word of that port is the last word sampled at a core clock edge with the qualifier high. Zero is used if no such word has been sampled since reset.
- R9: A rising edge of a direction clock while its latch enable is high stores only the transparent word already passing through. After the latch enable drops, the output keeps that word.
- R10: Each port's drive enable depends only on that port's own enable input. Both directions may be enabled together. Random sequences of enables, clocks and data on both paths match a cycle model of R2 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | WIDTH | Word seen on port A |
| a_in_vld | input | 1 | High when an outside driver is driving port A |
| b_in | input | WIDTH | Word seen on port B |
| b_in_vld | input | 1 | High when an outside driver is driving port B |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ab | input | 1 | A-to-B latch enable (high: transparent) |
| clk_ab | input | 1 | A-to-B direction clock |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable (high: transparent) |
| clk_ba | input | 1 | B-to-A direction clock |
| a_out | output | WIDTH | Word to drive onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_out | output | WIDTH | Word to drive onto port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
The assertions assume that the direction clocks and latch enables change only between core clock edges. They also assume that both direction clocks are low while reset is applied, so the first edge after reset is judged correctly. The stimulus changes every input on the falling edge of `clk` and holds `clk_ab`/`clk_ba` low through reset. It never raises a port's driven qualifier while the block is driving that port. The bench counts any case where a port is driven from both ends as a failure.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;

   // Control bundle of one direction, normalised to active-high enable.
   typedef struct packed {
      logic drive;
      logic transp;
      logic dclk;
   } dir_ctrl_t;

   function automatic dir_ctrl_t mk_ctrl(input logic oe_act_hi, input logic le,
                                         input logic dclk);
      dir_ctrl_t c;
      c.drive  = oe_act_hi;
      c.transp = le;
      c.dclk   = dclk;
      return c;
   endfunction

   localparam int unsigned MIN_WIDTH = 1;

endpackage

// File: rtl/bidir_xcvr_hold.sv
module bidir_xcvr_hold #(
   parameter int unsigned WIDTH   = 18,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   input  logic             pin_vld,
   output logic [WIDTH-1:0] eff
);

   generate
      if (HOLD_EN) begin : g_hold
         logic [WIDTH-1:0] kept_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       kept_q <= '0;
            else if (pin_vld) kept_q <= pin;
         end

         assign eff = pin_vld ? pin : kept_q;
      end else begin : g_nohold
         logic unused_vld;
         assign unused_vld = pin_vld;
         assign eff        = pin;
      end
   endgenerate

endmodule

// File: rtl/bidir_xcvr_path.sv
module bidir_xcvr_path
   import bidir_xcvr_pkg::*;
#(
   parameter int unsigned WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] src,
   input  dir_ctrl_t        ctrl,
   output logic [WIDTH-1:0] dout,
   output logic             drive
);

   logic             dclk_prev_q;
   logic             dclk_rise;
   logic             load;
   logic [WIDTH-1:0] store_q;

   assign dclk_rise = ctrl.dclk & ~dclk_prev_q;
   // Transparent phase keeps storage tracking the source, so the word held
   // after the enable drops is the last one that passed through.
   assign load      = ctrl.transp | dclk_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dclk_prev_q <= 1'b0;
         store_q     <= '0;
      end else begin
         dclk_prev_q <= ctrl.dclk;
         if (load) store_q <= src;
      end
   end

   assign dout  = ctrl.transp ? src : store_q;
   assign drive = ctrl.drive;

endmodule

// File: rtl/bidir_xcvr.sv
module bidir_xcvr
   import bidir_xcvr_pkg::*;
#(
   parameter int unsigned WIDTH   = 18,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic             a_in_vld,
   input  logic [WIDTH-1:0] b_in,
   input  logic             b_in_vld,
   input  logic             oe_ab,
   input  logic             le_ab,
   input  logic             clk_ab,
   input  logic             oe_ba_n,
   input  logic             le_ba,
   input  logic             clk_ba,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   generate
      if (WIDTH < MIN_WIDTH) begin : g_bad_width
         $error("bidir_xcvr: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] a_eff;
   logic [WIDTH-1:0] b_eff;
   dir_ctrl_t        ctl_ab;
   dir_ctrl_t        ctl_ba;

   assign ctl_ab = mk_ctrl(oe_ab,    le_ab, clk_ab);
   assign ctl_ba = mk_ctrl(~oe_ba_n, le_ba, clk_ba);

   bidir_xcvr_hold #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) hold_a_i (
      .clk(clk), .rst_n(rst_n), .pin(a_in), .pin_vld(a_in_vld), .eff(a_eff));

   bidir_xcvr_hold #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) hold_b_i (
      .clk(clk), .rst_n(rst_n), .pin(b_in), .pin_vld(b_in_vld), .eff(b_eff));

   bidir_xcvr_path #(.WIDTH(WIDTH)) path_ab_i (
      .clk(clk), .rst_n(rst_n), .src(a_eff), .ctrl(ctl_ab),
      .dout(b_out), .drive(b_oe));

   bidir_xcvr_path #(.WIDTH(WIDTH)) path_ba_i (
      .clk(clk), .rst_n(rst_n), .src(b_eff), .ctrl(ctl_ba),
      .dout(a_out), .drive(a_oe));

endmodule

// File: rtl/bidir_xcvr_chk.sv
module bidir_xcvr_chk #(
   parameter int unsigned WIDTH = 18
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic             a_in_vld,
   input logic [WIDTH-1:0] b_in,
   input logic             b_in_vld,
   input logic             oe_ab,
   input logic             le_ab,
   input logic             clk_ab,
   input logic             oe_ba_n,
   input logic             le_ba,
   input logic             clk_ba,
   input logic [WIDTH-1:0] a_out,
   input logic             a_oe,
   input logic [WIDTH-1:0] b_out,
   input logic             b_oe
);

   // R2: transparent A to B with A driven
   a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
      (le_ab && a_in_vld) |-> (b_out == a_in));

   // R3: latch closed, no clock rise last cycle -> output unchanged
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab && $past(!le_ab) && !$past(clk_ab)) |-> $stable(b_out));

   // R4: rising clk_ab while closed captures the driven A word
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!le_ab && $past(!le_ab) && $past(clk_ab) && !$past(clk_ab, 2) && $past(a_in_vld))
      |-> (b_out == $past(a_in)));

   // R5 and R7: drive enables follow their own polarity
   a_r5_oe_ab: assert property (@(posedge clk) disable iff (!rst_n)
      b_oe |-> oe_ab);
   a_r7_oe_ba: assert property (@(posedge clk) disable iff (!rst_n)
      a_oe |-> !oe_ba_n);

   // R6: B to A transparent with B driven
   a_r6_transparent_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (le_ba && b_in_vld) |-> (a_out == b_in));

   // R8: A floats while transparent -> last driven word persists
   a_r8_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (le_ab && $past(le_ab) && !a_in_vld && $past(!a_in_vld)) |-> $stable(b_out));

endmodule

bind bidir_xcvr bidir_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_vld(a_in_vld),
   .b_in(b_in), .b_in_vld(b_in_vld), .oe_ab(oe_ab), .le_ab(le_ab),
   .clk_ab(clk_ab), .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba),
   .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

// File: tb/bidir_xcvr_tb_top.sv
module bidir_xcvr_tb_top;
   localparam int W = 18;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         a_in_vld = 1'b0, b_in_vld = 1'b0;
   logic         oe_ab = 1'b0, le_ab = 1'b0, clk_ab = 1'b0;
   logic         oe_ba_n = 1'b1, le_ba = 1'b0, clk_ba = 1'b0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bidir_xcvr #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_in_vld(a_in_vld),
      .b_in(b_in), .b_in_vld(b_in_vld), .oe_ab(oe_ab), .le_ab(le_ab),
      .clk_ab(clk_ab), .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe));

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // R10: contention monitor, a port driven from both ends
   always @(negedge clk) begin
      if (rst_n && ((a_oe && a_in_vld) || (b_oe && b_in_vld))) begin
         errors++;
         $display("FAIL R10 contention actual=%b%b expected=00", a_oe && a_in_vld, b_oe && b_in_vld);
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      #1;
      chk("R1 b_out in reset", b_out, '0);
      chk("R1 a_out in reset", a_out, '0);
      step(); rst_n = 1'b1;
      step(); #1;
      chk("R1 b_out after reset", b_out, '0);
      chk("R1 a_out after reset", a_out, '0);
   endtask

   task automatic t_transparent_ab();
      a_in_vld = 1'b1; le_ab = 1'b1; oe_ab = 1'b1;
      foreach (a_in[i]) ;
      a_in = 18'h2AAAA; #1; chk("R2 pattern1", b_out, 18'h2AAAA);
      a_in = 18'h15555; #1; chk("R2 pattern2", b_out, 18'h15555);
      a_in = 18'h3FFFF; #1; chk("R2 ones", b_out, 18'h3FFFF);
      chk("R5 b_oe high", {17'b0, b_oe}, 18'd1);
   endtask

   task automatic t_hold_ab();
      step(); a_in = 18'h01234; le_ab = 1'b1;
      step(); le_ab = 1'b0; a_in = 18'h0BEEF; #1;
      chk("R3 held after close", b_out, 18'h01234);
      step(); clk_ab = 1'b1; a_in = 18'h0FACE;
      step(); #1; chk("R4 rising capture", b_out, 18'h0FACE);
      a_in = 18'h00777;
      step(); #1; chk("R4 clock held high no capture", b_out, 18'h0FACE);
      clk_ab = 1'b0;
      step(); #1; chk("R4 falling edge no capture", b_out, 18'h0FACE);
      step(); #1; chk("R3 still held", b_out, 18'h0FACE);
   endtask

   task automatic t_le_clock();
      le_ab = 1'b1; a_in = 18'h13579; clk_ab = 1'b1; #1;
      chk("R9 transparent during edge", b_out, 18'h13579);
      step(); le_ab = 1'b0; a_in = 18'h02468; #1;
      chk("R9 keeps transparent word", b_out, 18'h13579);
      clk_ab = 1'b0;
      step();
   endtask

   task automatic t_oe();
      oe_ab = 1'b0; a_in = 18'h0AAAA; le_ab = 1'b1; #1;
      chk("R5 b_oe low", {17'b0, b_oe}, 18'd0);
      chk("R5 data still computed", b_out, 18'h0AAAA);
      oe_ba_n = 1'b1; #1; chk("R7 a_oe off", {17'b0, a_oe}, 18'd0);
      a_in_vld = 1'b0; oe_ba_n = 1'b0; #1; chk("R7 a_oe on", {17'b0, a_oe}, 18'd1);
      oe_ab = 1'b1; #1;
      chk("R10 both enabled b_oe", {17'b0, b_oe}, 18'd1);
      chk("R10 both enabled a_oe", {17'b0, a_oe}, 18'd1);
      oe_ab = 1'b0; oe_ba_n = 1'b1; a_in_vld = 1'b1;
      step();
   endtask

   task automatic t_ba();
      b_in_vld = 1'b1; le_ba = 1'b1; b_in = 18'h3C3C3; #1;
      chk("R6 transparent B to A", a_out, 18'h3C3C3);
      step(); le_ba = 1'b0; b_in = 18'h00001; #1;
      chk("R6 hold B to A", a_out, 18'h3C3C3);
      step(); clk_ba = 1'b1;
      step(); #1; chk("R6 capture B to A", a_out, 18'h00001);
      clk_ba = 1'b0; step();
   endtask

   task automatic t_bushold();
      le_ab = 1'b1; a_in_vld = 1'b1; a_in = 18'h2D2D2;
      step(); a_in_vld = 1'b0; a_in = 18'h10101; #1;
      chk("R8 floating A held", b_out, 18'h2D2D2);
      step(); #1; chk("R8 floating A held later", b_out, 18'h2D2D2);
      b_in_vld = 1'b0; le_ba = 1'b1; b_in = 18'h3FFFF; #1;
      chk("R8 floating B held", a_out, 18'h00001);
      a_in_vld = 1'b1; b_in_vld = 1'b1; step();
   endtask

   task automatic t_random();
      logic [W-1:0] q_ab = b_out, q_ba = a_out, h_a = a_in, h_b = b_in;
      logic pr_ab = clk_ab, pr_ba = clk_ba;
      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] ea, eb;
         @(negedge clk);
         oe_ab = $urandom_range(0, 1); oe_ba_n = $urandom_range(0, 1);
         le_ab = ($urandom_range(0, 3) == 0); le_ba = ($urandom_range(0, 3) == 0);
         clk_ab = $urandom_range(0, 1); clk_ba = $urandom_range(0, 1);
         a_in = W'($urandom); b_in = W'($urandom);
         a_in_vld = oe_ba_n ? 1'($urandom_range(0, 1)) : 1'b0;
         b_in_vld = oe_ab ? 1'b0 : 1'($urandom_range(0, 1));
         #1;
         ea = a_in_vld ? a_in : h_a;
         eb = b_in_vld ? b_in : h_b;
         chk("R10 random b_out", b_out, le_ab ? ea : q_ab);
         chk("R10 random a_out", a_out, le_ba ? eb : q_ba);
         chk("R10 random oe", {16'b0, a_oe, b_oe}, {16'b0, ~oe_ba_n, oe_ab});
         @(posedge clk);
         if (le_ab || (clk_ab && !pr_ab)) q_ab = ea;
         if (le_ba || (clk_ba && !pr_ba)) q_ba = eb;
         pr_ab = clk_ab; pr_ba = clk_ba;
         if (a_in_vld) h_a = a_in;
         if (b_in_vld) h_b = b_in;
      end
   endtask

   initial begin
      #5000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_transparent_ab();
      t_hold_ab();
      t_le_clock();
      t_oe();
      t_ba();
      t_bushold();
      t_random();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule